// File: doc/BRIEF.md
# Byte-Field Logical Operation Unit

This datapath stage applies one two-input Boolean function to a chosen sub-field of a 16-bit logical word and registers the updated word. The accumulator half word and a memory operand half word come in together with three control fields: a size code, a position index and a 4-bit connective code. The size code divides the word into equal fields of 16, 8, 4, 2 or 1 bits. The position index picks one of those fields. The connective code is a truth table that selects any of the sixteen functions of two bits.

Inside the selected field, each result bit is the chosen function of the accumulator bit and the operand bit at the same position. Every accumulator bit outside the field passes through unchanged. So a single operation does a masked AND, OR, XOR, set, clear, invert or copy on a byte, nibble, bit pair or single bit, with no mask built in software. A zero flag shows whether the selected field of the result is all zeros. Both outputs register on the clock edge at which the start strobe is high, and hold in every other cycle.

Top module: `bytefield_lu`

## Requirements
- R1: After reset, `acc_out` is 16'h0000 and `zero_out` is 1.
- R2: The size code sets the field width W. Code 0 gives 16 bits, 1 gives 8, 2 gives 4, 3 gives 2 and 4 gives 1. Codes 5, 6 and 7 are treated as code 4 (1 bit).
- R3: With width W, field k covers bits k*W+W-1 down to k*W. Field 0 holds the least significant bits.
- R4: Only the low log2(16/W) bits of `pos_idx` are used and the higher bits are ignored. With W = 16, the index has no effect.
- R5: Inside the field, result bit i equals `func[{acc_in[i], opnd_in[i]}]`. Bit index 2*a+b of the code is the output for accumulator bit a and operand bit b. For example, 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR and 4'b1100 copies the accumulator.
- R6: Every bit of `acc_out` outside the selected field equals the `acc_in` bit sampled with the strobe.
- R7: The operand bits used are taken from the same positions as the target field. Operand bits outside the field have no effect on the result.
- R8: `zero_out` is 1 exactly when the selected field of the result is all zeros. Bits outside the field do not affect it.
- R9: Both outputs update only on a rising clock edge with `start` high. They are stable while `start` is low, whatever the other inputs do.
- R10: A result is visible on the outputs right after the rising edge that samples `start`, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe: register a new result on this edge |
| acc_in | input | 16 | Accumulator half word |
| opnd_in | input | 16 | Memory operand half word |
| size_code | input | 3 | Field width code |
| pos_idx | input | 4 | Field position index |
| func | input | 4 | Connective truth table |
| acc_out | output | 16 | Registered updated accumulator |
| zero_out | output | 1 | Registered zero flag of the selected field |

## Verification
A wrong field mask, either misplaced or of the wrong width, shows on `acc_out` in the cycle after the strobe. It appears either as outside bits that change or as field bits that do not follow the connective. Running all sixteen codes against chosen bit pairs exposes a swapped truth-table index in that same cycle. A zero flag computed over the wrong bits diverges from the field content one cycle after the strobe. A register that loads without the strobe shows as an output change during idle cycles.

// File: rtl/blu_pkg.sv
package blu_pkg;
    localparam int BLU_W   = 16;
    localparam int BLU_SZW = 3;

    // Saturate an oversized size code to the narrowest legal field.
    function automatic logic [BLU_SZW-1:0] clamp_size(input logic [BLU_SZW-1:0] code,
                                                     input int lvls);
        if (int'(code) > lvls - 1)
            return BLU_SZW'(lvls - 1);
        return code;
    endfunction
endpackage

// File: rtl/blu_mask_gen.sv
module blu_mask_gen
    import blu_pkg::*;
#(
    parameter int DATA_W = BLU_W,
    parameter int SZ_W   = BLU_SZW,
    localparam int POS_W = $clog2(DATA_W),
    localparam int LVLS  = POS_W + 1
) (
    input  logic [SZ_W-1:0]   size_code,
    input  logic [POS_W-1:0]  pos_idx,
    output logic [DATA_W-1:0] mask
);
    logic [SZ_W-1:0]  code_c;
    logic [SZ_W-1:0]  shamt;
    logic [POS_W-1:0] pos_lim;
    logic [POS_W-1:0] pos_m;

    always_comb begin
        code_c  = clamp_size(size_code, LVLS);
        // log2 of field width: widest field for code 0
        shamt   = SZ_W'(LVLS - 1) - code_c;
        pos_lim = POS_W'((1 << code_c) - 1);
        pos_m   = pos_idx & pos_lim;
    end

    // One comparator per bit: bit i is in the field if its field index matches.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [POS_W-1:0] fld_idx;
        assign fld_idx = POS_W'(i) >> shamt;
        assign mask[i] = (fld_idx == pos_m);
    end
endmodule

// File: rtl/blu_connective.sv
module blu_connective
    import blu_pkg::*;
#(
    parameter int DATA_W = BLU_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        func,
    output logic [DATA_W-1:0] y
);
    // Each bit looks up its own truth-table entry, indexed {a,b}.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lut
        assign y[i] = func[{a[i], b[i]}];
    end
endmodule

// File: rtl/blu_zero_det.sv
module blu_zero_det
    import blu_pkg::*;
#(
    parameter int DATA_W = BLU_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    output logic              is_zero
);
    assign is_zero = ~|(data & mask);
endmodule

// File: rtl/bytefield_lu.sv
module bytefield_lu
    import blu_pkg::*;
#(
    parameter int DATA_W = BLU_W,
    parameter int SZ_W   = BLU_SZW,
    localparam int POS_W = $clog2(DATA_W),
    localparam int LVLS  = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [SZ_W-1:0]   size_code,
    input  logic [POS_W-1:0]  pos_idx,
    input  logic [3:0]        func,
    output logic [DATA_W-1:0] acc_out,
    output logic              zero_out
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              zero;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] fres;
    logic [DATA_W-1:0] merged;
    logic              fld_zero;

    blu_mask_gen #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_mask (
        .size_code (size_code),
        .pos_idx   (pos_idx),
        .mask      (mask)
    );

    blu_connective #(.DATA_W(DATA_W)) u_conn (
        .a    (acc_in),
        .b    (opnd_in),
        .func (func),
        .y    (fres)
    );

    blu_zero_det #(.DATA_W(DATA_W)) u_zero (
        .data    (fres),
        .mask    (mask),
        .is_zero (fld_zero)
    );

    always_comb begin
        merged = (acc_in & ~mask) | (fres & mask);
        st_d   = st_q;
        if (start) begin
            st_d.acc  = merged;
            st_d.zero = fld_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.zero <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out  = st_q.acc;
    assign zero_out = st_q.zero;

    // R2: mask population matches the field width chosen by the size code
    a_r2_field_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == (DATA_W >> clamp_size(size_code, LVLS)));

    // R6: bits outside the field follow the sampled accumulator
    a_r6_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((acc_out & ~$past(mask)) == ($past(acc_in) & ~$past(mask))));

    // R8: flag agrees with the registered field content
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (zero_out == ((acc_out & $past(mask)) == '0)));

    // R9: no strobe, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_out) && $stable(zero_out)));
endmodule

// File: tb/tb_bytefield_lu.sv
module tb_bytefield_lu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] acc_in = '0;
    logic [15:0] opnd_in = '0;
    logic [2:0]  size_code = '0;
    logic [3:0]  pos_idx = '0;
    logic [3:0]  func = '0;
    logic [15:0] acc_out;
    logic        zero_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytefield_lu dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .acc_in(acc_in), .opnd_in(opnd_in),
        .size_code(size_code), .pos_idx(pos_idx), .func(func),
        .acc_out(acc_out), .zero_out(zero_out)
    );

    // Independent model written from the requirements.
    function automatic void model(input logic [2:0] sz, input logic [3:0] pos,
                                  input logic [3:0] f, input logic [15:0] a,
                                  input logic [15:0] b,
                                  output logic [15:0] r, output logic z);
        int w;
        int nf;
        int p;
        w  = (sz >= 3'd4) ? 1 : (16 / (1 << sz));
        nf = 16 / w;
        p  = int'(pos) % nf;
        z  = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if ((i / w) == p) begin
                r[i] = f[2*int'(a[i]) + int'(b[i])];
                if (r[i]) z = 1'b0;
            end else begin
                r[i] = a[i];
            end
        end
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] sz, input logic [3:0] pos,
                          input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] er;
        logic        ez;
        model(sz, pos, f, a, b, er, ez);
        @(negedge clk);
        size_code = sz; pos_idx = pos; func = f; acc_in = a; opnd_in = b; start = 1'b1;
        @(posedge clk);
        #1;
        check({req, " acc"}, acc_out, er);
        check({req, " zero"}, {15'd0, zero_out}, {15'd0, ez});
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 acc", acc_out, 16'h0000);
        check("R1 zero", {15'd0, zero_out}, 16'd1);
    endtask

    task automatic t_connectives;
        // R5: all 16 functions on an 8-bit field holding every {a,b} pair
        for (int f = 0; f < 16; f++)
            run_op("R5 conn", 3'd1, 4'd1, 4'(f), 16'h33A5, 16'h555A);
    endtask

    task automatic t_sizes;
        // R2 and R10: each size code, legal and saturated
        for (int s = 0; s < 8; s++)
            run_op("R2 size", 3'(s), 4'd0, 4'b0110, 16'hF0F0, 16'hFFFF);
    endtask

    task automatic t_positions;
        // R3: each nibble position, OR sets only that nibble
        for (int p = 0; p < 4; p++)
            run_op("R3 pos", 3'd2, 4'(p), 4'b1110, 16'h0000, 16'hFFFF);
        for (int p = 0; p < 16; p++)
            run_op("R3 bit", 3'd4, 4'(p), 4'b0011, 16'hA5C3, 16'h0000);
    endtask

    task automatic t_pos_mask;
        // R4: high index bits ignored
        run_op("R4 wrap8", 3'd1, 4'd3, 4'b0011, 16'h1234, 16'h0000);
        run_op("R4 wrap2", 3'd3, 4'd13, 4'b1010, 16'h0000, 16'hFFFF);
        run_op("R4 full", 3'd0, 4'd9, 4'b0101, 16'hFFFF, 16'h0F0F);
    endtask

    task automatic t_outside;
        // R6 and R7: operand outside field irrelevant, accumulator outside kept
        run_op("R6 keep", 3'd3, 4'd2, 4'b0000, 16'hFFFF, 16'hFFFF);
        run_op("R7 opnd", 3'd1, 4'd0, 4'b1010, 16'hBEEF, 16'hFF00);
    endtask

    task automatic t_zero;
        // R8: field zero while outside bits are set, and field nonzero
        run_op("R8 zero", 3'd2, 4'd1, 4'b1000, 16'hFF0F, 16'h00F0);
        run_op("R8 nz", 3'd2, 4'd1, 4'b1000, 16'h0010, 16'h0010);
    endtask

    task automatic t_hold;
        logic [15:0] held;
        logic        hz;
        run_op("R9 setup", 3'd0, 4'd0, 4'b1100, 16'h5A5A, 16'h0000);
        held = 16'h5A5A;
        hz   = 1'b0;
        @(negedge clk);
        acc_in = 16'h0000; opnd_in = 16'hFFFF; func = 4'b0000; size_code = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 hold acc", acc_out, held);
        check("R9 hold zero", {15'd0, zero_out}, {15'd0, hz});
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_connectives();
        t_sizes();
        t_positions();
        t_pos_mask();
        t_outside();
        t_zero();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule